// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block lets a clocked system read and write an external asynchronous static RAM holding 131,072 words of 16 bits. The user side offers a request/ready handshake that carries a 17-bit word address, a direction bit, 16 bits of write data and a two-bit byte-enable. Read results come back on a 16-bit bus with a single-cycle valid strobe. Each access can touch the lower byte, the upper byte or both.

On the memory side the controller drives the address and two chip enables of opposite polarity: the first is active low and the second is active high. It also drives an active-low output enable, an active-low write enable and separate active-low lower-byte and upper-byte selects. The bidirectional data bus is split into a driven value, a sampled value and a drive-enable. Each strobe phase (write enable low, or output enable low) lasts a number of cycles derived at elaboration from the clock period and the access time of the memory. Between accesses the memory is left deselected, so it stays in standby.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, the memory is idle: `mem_ce1_n`=1, `mem_ce2`=0, `mem_lb_n`=`mem_ub_n`=1, `mem_we_n`=`mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: The strobe length is WAIT = ceil(ACCESS_PS / CLK_PS), with a minimum of 1. With the defaults (4000 ps, 55000 ps) this is 14. Write enable stays low for exactly WAIT cycles per write, and output enable stays low for exactly WAIT cycles per read.
- R3: For a write, the address, the chip enables and the byte selects are valid one cycle before `mem_we_n` falls. They are held unchanged for one cycle after it rises, and the address does not move while `mem_we_n` is low.
- R4: During an access `mem_lb_n` is low exactly when `req_be[0]` was set and `mem_ub_n` is low exactly when `req_be[1]` was set. Bit 0 of the byte-enable governs data bits 7:0 and bit 1 governs bits 15:8.
- R5: A write changes only the memory lanes that it enables. The other byte of the word keeps its previous contents.
- R6: `mem_dq_oe` is high only during write accesses, never while `mem_oe_n` is low, and is low in the cycle before `mem_oe_n` falls.
- R7: Read data is registered after the last output-enable cycle. `rsp_valid` pulses for one cycle, WAIT+1 clock edges after the accepting edge, and lanes that the request did not enable read as zero.
- R8: A request with `req_be`=00 is accepted without any memory cycle: the chip enables never activate and `req_ready` stays high. A read of this kind returns `rsp_valid` with all-zero data one edge after acceptance.
- R9: A request with a non-zero byte-enable drops `req_ready` from the cycle after acceptance until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_in | input | 16 | Data sampled from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench drives the controller with directed full-word, low-byte-only, high-byte-only and zero-enable transactions, followed by a long random mix over a small address pool so that earlier data is read back. Partial writes followed by full reads tell lane-masked writes apart from whole-word writes. Partial reads tell zeroed lanes apart from leaked bus values. The memory model in the bench returns junk until output enable has been low for WAIT cycles, so a short wait count shows up as wrong data. Zero-enable requests separate a true no-op from a hidden memory cycle through chip-enable activity and the `req_ready` timing.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RSETUP,
    ST_RWAIT
  } sbc_state_e;

  // Strobe cycles: ceiling of access time over clock period, at least one.
  function automatic int unsigned wait_cycles(int unsigned access_ps, int unsigned clk_ps);
    int unsigned n;
    n = (access_ps + clk_ps - 1) / clk_ps;
    if (n == 0) n = 1;
    return n;
  endfunction

  // Width of a down-counter that must hold n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sbc_wait_timer.sv
module sbc_wait_timer #(
  parameter int unsigned WAIT = 14,
  parameter int unsigned CW   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= CW'(WAIT - 1);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R2: count never exceeds the loaded strobe length
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WAIT - 1));

  // R2: a load is followed by a full count unless the strobe is one cycle
  p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == CW'(WAIT - 1)));
endmodule

// File: rtl/sbc_byte_lanes.sv
module sbc_byte_lanes #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic [LANES-1:0]  sel_be,
  input  logic              cap_en,
  input  logic [LANES-1:0]  cap_be,
  input  logic [DATA_W-1:0] bus_in,
  output logic [LANES-1:0]  bsel_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_en;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] q;

    assign bsel_n[i] = ~(sel_en & sel_be[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (cap_en) q <= cap_be[i] ? bus_in[i*8 +: 8] : 8'h00;
    end

    assign rd_data[i*8 +: 8] = q;

    // R7: a lane left out of the capture reads zero
    p_off_lane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !cap_be[i]) |=> (rd_data[i*8 +: 8] == 8'h00));

    // R4: no byte select while the chip is not being accessed
    p_sel_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_en |-> bsel_n[i]);
  end
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned ACCESS_PS = 55000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned WAIT  = wait_cycles(ACCESS_PS, CLK_PS);
  localparam int unsigned CW    = cnt_width(WAIT);

  sbc_state_e state, state_nx;

  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata;
  logic [LANES-1:0]  a_be;

  // Named internal events
  logic accept, be_none, zero_read, timer_load, timer_run, timer_done;
  logic access_on, read_cap;
  logic [LANES-1:0] bsel_n, cap_be;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign be_none    = (req_be == '0);
  assign zero_read  = accept && be_none && !req_write;
  assign timer_load = (state == ST_WSETUP) || (state == ST_RSETUP);
  assign timer_run  = (state == ST_WPULSE) || (state == ST_RWAIT);
  assign access_on  = (state != ST_IDLE);
  assign read_cap   = ((state == ST_RWAIT) && timer_done) || zero_read;
  assign cap_be     = (state == ST_IDLE) ? LANES'(req_be) : a_be;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept && !be_none) state_nx = req_write ? ST_WSETUP : ST_RSETUP;
      ST_WSETUP: state_nx = ST_WPULSE;
      ST_WPULSE: if (timer_done) state_nx = ST_WHOLD;
      ST_WHOLD:  state_nx = ST_IDLE;
      ST_RSETUP: state_nx = ST_RWAIT;
      ST_RWAIT:  if (timer_done) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      a_addr  <= '0;
      a_wdata <= '0;
      a_be    <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        a_addr  <= req_addr;
        a_wdata <= req_wdata;
        a_be    <= LANES'(req_be);
      end
    end
  end

  sbc_wait_timer #(.WAIT(WAIT), .CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .run     (timer_run),
    .expired (timer_done)
  );

  sbc_byte_lanes #(.LANES(LANES), .DATA_W(DATA_W)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_en   (access_on),
    .sel_be   (a_be),
    .cap_en   (read_cap),
    .cap_be   (cap_be),
    .bus_in   (mem_dq_in),
    .bsel_n   (bsel_n),
    .rd_data  (rsp_rdata),
    .rd_valid (rsp_valid)
  );

  assign mem_addr   = a_addr;
  assign mem_ce1_n  = !access_on;
  assign mem_ce2    = access_on;
  assign mem_we_n   = !(state == ST_WPULSE);
  assign mem_oe_n   = !(state == ST_RWAIT);
  assign mem_dq_oe  = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
  assign mem_dq_out = a_wdata;
  assign mem_lb_n   = bsel_n[0];
  assign mem_ub_n   = bsel_n[LANES-1];

  // R1: a ready controller leaves the memory deselected and quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_lb_n && mem_ub_n &&
                   mem_we_n && mem_oe_n && !mem_dq_oe));

  // R3: address, enables and selects already set when write enable falls
  p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_lb_n) &&
                         $stable(mem_ub_n) && !mem_ce1_n && $stable(mem_ce1_n)));

  // R3: one cycle of hold after write enable rises
  p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && $stable(mem_addr) &&
                         $stable(mem_lb_n) && $stable(mem_ub_n)));

  // R3: address steady through the write pulse
  p_we_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  // R6: the controller and the memory never drive the bus together
  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R6: bus released for a cycle before output enable falls
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R8: a zero byte-enable request leaves the controller ready and deselected
  p_be_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && be_none) |=> (req_ready && mem_ce1_n));

  // R9: a real access removes ready in the next cycle
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !be_none) |=> !req_ready);
endmodule

// File: tb/sram_byte_ctrl_test.sv
module sram_byte_ctrl_test;
  localparam int CLK_PS    = 4000;
  localparam int ACCESS_PS = 55000;

  // Strobe length restated by repeated subtraction
  function automatic int strobe_len(int acc, int per);
    int n, left;
    n = 0; left = acc;
    while (left > 0) begin left -= per; n++; end
    return (n < 1) ? 1 : n;
  endfunction
  localparam int WAIT = strobe_len(ACCESS_PS, CLK_PS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hA5A5;

  always #2ns clk = ~clk;

  sram_byte_ctrl #(.CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(logic [16:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  // Memory as seen by the bench (expected) and as held by the model chip
  logic [15:0] exp_mem [int];
  logic [15:0] chip_mem [int];

  function automatic logic [15:0] exp_get(logic [16:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [15:0] chip_get(logic [16:0] a);
    return chip_mem.exists(int'(a)) ? chip_mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [15:0] lane_mask(logic [15:0] v, logic [1:0] be);
    return v & {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // Model chip plus protocol monitors
  int oe_cnt = 0;
  int we_run = 0, last_we_len = 0, act_cnt = 0;
  int fight_bad = 0, setup_bad = 0, hold_bad = 0, move_bad = 0;
  logic p_we = 1, p_ce1 = 1, p_lb = 1, p_ub = 1;
  logic [16:0] p_addr = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      logic sel;
      sel = !mem_ce1_n && mem_ce2;
      if (sel && !mem_we_n && mem_dq_oe) begin
        logic [15:0] w;
        w = chip_get(mem_addr);
        if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
        chip_mem[int'(mem_addr)] = w;
      end
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin last_we_len = we_run; we_run = 0; end
      if (!mem_ce1_n) act_cnt++;
      if (mem_dq_oe && !mem_oe_n) fight_bad++;
      if (p_we && !mem_we_n && !(p_ce1 == 0 && p_addr == mem_addr && p_lb == mem_lb_n && p_ub == mem_ub_n))
        setup_bad++;
      if (!p_we && mem_we_n && !(mem_ce1_n == 0 && p_addr == mem_addr && p_lb == mem_lb_n && p_ub == mem_ub_n))
        hold_bad++;
      if (!p_we && !mem_we_n && p_addr != mem_addr) move_bad++;
      oe_cnt <= !mem_oe_n ? oe_cnt + 1 : 0;
      p_we = mem_we_n; p_ce1 = mem_ce1_n; p_lb = mem_lb_n; p_ub = mem_ub_n; p_addr = mem_addr;
    end
  end

  // Read data appears only once output enable has been low for the access time
  always @(negedge clk) begin
    logic [15:0] r, wd;
    r = 16'hA5A5;
    if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n && oe_cnt >= WAIT - 1) begin
      wd = chip_get(mem_addr);
      if (!mem_lb_n) r[7:0]  = wd[7:0];
      if (!mem_ub_n) r[15:8] = wd[15:8];
    end
    mem_dq_in <= r;
  end

  task automatic check_idle(input string tag);
    chk(mem_ce1_n && !mem_ce2 && mem_lb_n && mem_ub_n && mem_we_n && mem_oe_n && !mem_dq_oe,
        tag, {25'd0, mem_ce1_n, mem_ce2, mem_lb_n, mem_ub_n, mem_we_n, mem_oe_n, mem_dq_oe},
        32'b1011110);
  endtask

  task automatic wait_ready();
    int k = 0;
    while (!req_ready && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    act_cnt = 0; last_we_len = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (be == 2'b00) begin
      chk(req_ready, "R8 zero-enable write keeps ready", {31'd0, req_ready}, 1);
    end else begin
      logic [15:0] w;
      chk(!req_ready, "R9 ready drops after write accept", {31'd0, req_ready}, 0);
      wait_ready();
      chk(last_we_len == WAIT, "R2 write pulse length", last_we_len, WAIT);
      w = exp_get(a);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      exp_mem[int'(a)] = w;
    end
    if (be == 2'b00) chk(act_cnt == 0, "R8 no chip enable on zero-enable write", act_cnt, 0);
    check_idle("R1 idle after write");
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] be);
    logic [15:0] e;
    @(negedge clk); wait_ready();
    req_valid = 1; req_write = 0; req_addr = a; req_be = be; act_cnt = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    e = lane_mask(exp_get(a), be);
    if (be == 2'b00) begin
      chk(rsp_valid, "R8 zero-enable read answers at once", {31'd0, rsp_valid}, 1);
      chk(rsp_rdata == 16'h0, "R8 zero-enable read data", rsp_rdata, 0);
      chk(act_cnt == 0 && req_ready, "R8 no memory cycle on zero-enable read", act_cnt, 0);
    end else begin
      int n = 0;
      chk(!req_ready, "R9 ready drops after read accept", {31'd0, req_ready}, 0);
      while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
      chk(n == WAIT + 1, "R7 read latency", n, WAIT + 1);
      chk(rsp_rdata == e, "R5 R7 read data by lane", rsp_rdata, e);
      @(negedge clk);
      chk(!rsp_valid, "R7 valid is one cycle", {31'd0, rsp_valid}, 0);
    end
    check_idle("R1 idle after read");
  endtask

  int cycles = 0;
  bit done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [16:0] pool [16];

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 reset state");
    chk(req_ready && !rsp_valid, "R1 ready after reset", {30'd0, req_ready, rsp_valid}, 2);

    // Directed cases
    do_write(17'h00000, 16'h1234, 2'b11);
    do_read (17'h00000, 2'b11);
    do_write(17'h00000, 16'hBEEF, 2'b01);     // low byte only
    do_read (17'h00000, 2'b11);               // expect 12EF
    do_write(17'h1FFFF, 16'hCAFE, 2'b10);     // high byte only at top address
    do_read (17'h1FFFF, 2'b11);
    do_read (17'h1FFFF, 2'b01);               // upper lane must read zero
    do_read (17'h00000, 2'b10);               // lower lane must read zero
    do_write(17'h00000, 16'hFFFF, 2'b00);     // no-op
    do_read (17'h00000, 2'b11);               // unchanged
    do_read (17'h00000, 2'b00);

    // Constrained random mix over a small pool
    for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
    pool[0] = 17'h00000; pool[1] = 17'h1FFFF;
    for (int i = 0; i < 240; i++) begin
      logic [16:0] a;
      logic [1:0]  be;
      a  = pool[$urandom % 16];
      be = 2'($urandom);
      if ($urandom % 2 == 0) do_write(a, 16'($urandom), be);
      else                   do_read(a, be);
    end

    chk(fight_bad == 0, "R6 bus contention cycles", fight_bad, 0);
    chk(setup_bad == 0, "R3 setup before write pulse", setup_bad, 0);
    chk(hold_bad == 0,  "R3 hold after write pulse", hold_bad, 0);
    chk(move_bad == 0,  "R3 address move during pulse", move_bad, 0);
    chk(WAIT == 14,     "R2 derived strobe length", WAIT, 14);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule